// File: doc/BRIEF.md
# Buffer Descriptor Ring Sequencer

This block keeps a small ring of buffer descriptors in local registers and walks through it for one serial direction. Each descriptor carries a ready (owned-by-engine) flag, a per-buffer interrupt choice, a wrap flag, a byte length and a buffer index. The serial datapath sees the current descriptor on the `cur_*` outputs. It pulses `dp_done_i` when it has finished with that buffer. The sequencer then hands the descriptor back to the host by clearing its ready flag and, in the receive variant, stores the byte count. It then moves to the next entry.

A host port writes whole descriptors and reads any of them back. The host clears sticky events by writing ones and sets an event mask. Two events exist: buffer-done, which is raised only for descriptors that ask for it, and busy, which is raised when the receive ring runs dry. While the current descriptor is not ready, the sequencer waits on it. It continues as soon as the host arms that descriptor again. The `IS_RX` parameter selects the receive or the transmit variant.

Top module: `rb_ring_seq`

## Requirements
- R1: After reset, every descriptor reads as all zeros, `cur_ptr_o` is 0, and `evt_o`, the mask and `irq_o` are 0.
- R2: A host write with `host_we_i` stores `host_wdata_i` into entry `host_waddr_i`. The read port `host_rdata_o` returns entry `host_raddr_i` in the same format: bit 26 ready, bit 25 interrupt enable, bit 24 wrap, bits 23:8 length, bits 7:0 buffer index.
- R3: `cur_ready_o`, `cur_len_o` and `cur_buf_o` show the ready, length and buffer-index fields of the entry at `cur_ptr_o`.
- R4: A `dp_done_i` pulse while `cur_ready_o` is 1 clears the ready bit of the current entry by the next cycle. This holds even if the host writes that entry in the same cycle.
- R5: In the receive variant, an accepted completion replaces the entry's length with `dp_len_i`. In the transmit variant the length keeps the value the host wrote, which may be any byte count.
- R6: The buffer-done event (`evt_o[0]`) is set by an accepted completion exactly when the completed entry's interrupt-enable bit is 1.
- R7: After an accepted completion, `cur_ptr_o` becomes 0 if the completed entry has its wrap bit set or is the last entry (7). Otherwise it becomes the entry index plus 1.
- R8: In the receive variant, the busy event (`evt_o[1]`) is set by an accepted completion when the entry it moves to is not ready. A host write in the same cycle is taken into account. The transmit variant never sets busy.
- R9: A `dp_done_i` pulse while `cur_ready_o` is 0 has no effect on any descriptor, the pointer or the events.
- R10: While stalled, the sequencer re-checks the same entry every cycle. `cur_ready_o` rises in the cycle after the host sets that entry's ready bit, and the next `dp_done_i` is accepted.
- R11: Events are sticky. A 1 in `evt_clr_i` clears the matching bit, but a set in the same cycle wins.
- R12: `irq_o` is 1 exactly when some event bit is 1 and its mask bit is 1. The mask is loaded from `mask_wdata_i` when `mask_we_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_we_i | input | 1 | Descriptor write strobe |
| host_waddr_i | input | 3 | Entry to write |
| host_wdata_i | input | 27 | Descriptor value to write |
| host_raddr_i | input | 3 | Entry to read |
| host_rdata_o | output | 27 | Descriptor value read |
| evt_clr_i | input | 2 | Write-one-to-clear for the events |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 2 | New mask value |
| dp_done_i | input | 1 | Buffer-complete pulse from the datapath |
| dp_len_i | input | 16 | Bytes written into the completed receive buffer |
| cur_ready_o | output | 1 | Current entry is owned by the engine |
| cur_ptr_o | output | 3 | Index of the current entry |
| cur_len_o | output | 16 | Length field of the current entry |
| cur_buf_o | output | 8 | Buffer index of the current entry |
| evt_o | output | 2 | Sticky events: bit 0 buffer done, bit 1 busy |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The completion path is first driven with a short directed ring of three entries. The wrap bit closes that ring, only the middle entry requests an interrupt, and this separates wrap from sequential advance and interrupt-on from interrupt-off. The ring is then drained until it stalls, which is where busy appears for receive and not for transmit. The bench pulses completions while stalled and re-arms the waiting entry, which separates the ignored case from the resume case. Finally a long pseudo-random mix of host writes, completions, clears and mask changes runs against both variants at once. This mix covers writes that collide with a completion on the same or the next entry, a set and a clear in the same cycle, and wrap from the last entry, and all of it is compared with an arithmetic model of the ring.

// File: rtl/rb_pkg.sv
package rb_pkg;
    localparam int EVT_W    = 2;
    localparam int EVT_DONE = 0;
    localparam int EVT_BUSY = 1;
endpackage

// File: rtl/rb_desc_store.sv
module rb_desc_store import rb_pkg::*; #(
    parameter int NUM_DESC = 8,
    parameter int LEN_W    = 16,
    parameter int IDX_W    = 8,
    parameter bit IS_RX    = 1'b1,
    localparam int PW      = $clog2(NUM_DESC),
    localparam int DW      = 3 + LEN_W + IDX_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [PW-1:0]    wr_addr_i,
    input  logic [DW-1:0]    wr_data_i,
    input  logic [PW-1:0]    rd_addr_i,
    output logic [DW-1:0]    rd_data_o,
    input  logic [PW-1:0]    ptr_i,
    input  logic             cmp_en_i,
    input  logic [LEN_W-1:0] cmp_len_i,
    input  logic [PW-1:0]    nxt_ptr_i,
    output logic [DW-1:0]    cur_o,
    output logic             nxt_rdy_o
);
    typedef struct packed {
        logic             rdy;
        logic             ien;
        logic             wrap;
        logic [LEN_W-1:0] len;
        logic [IDX_W-1:0] bidx;
    } desc_t;

    typedef struct packed {
        desc_t [NUM_DESC-1:0] ent;
    } st_t;

    st_t st_d, st_q;
    logic [LEN_W-1:0] len_upd;
    logic             len_take;

    generate
        if (IS_RX) begin : g_rx_len
            assign len_take = 1'b1;
        end else begin : g_tx_len
            assign len_take = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (wr_en_i && int'(wr_addr_i) < NUM_DESC) begin
            st_d.ent[wr_addr_i] = desc_t'(wr_data_i);
        end
        len_upd = st_d.ent[ptr_i].len;
        if (len_take) begin
            len_upd = cmp_len_i;
        end
        if (cmp_en_i) begin
            st_d.ent[ptr_i].rdy = 1'b0;
            st_d.ent[ptr_i].len = len_upd;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.ent[rd_addr_i];
    assign cur_o     = st_q.ent[ptr_i];
    assign nxt_rdy_o = st_d.ent[nxt_ptr_i].rdy;

    // R4
    cmp_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmp_en_i |=> !st_q.ent[$past(ptr_i)].rdy);

    // R2
    wr_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !(cmp_en_i && wr_addr_i == ptr_i))
        |=> st_q.ent[$past(wr_addr_i)] == $past(wr_data_i));

    generate
        if (IS_RX) begin : g_rx_chk
            // R5
            rx_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                cmp_en_i |=> st_q.ent[$past(ptr_i)].len == $past(cmp_len_i));
        end
    endgenerate
endmodule

// File: rtl/rb_ptr_ctrl.sv
module rb_ptr_ctrl import rb_pkg::*; #(
    parameter int NUM_DESC = 8,
    parameter bit IS_RX    = 1'b1,
    localparam int PW      = $clog2(NUM_DESC)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             done_i,
    input  logic             cur_rdy_i,
    input  logic             cur_wrap_i,
    input  logic             cur_ien_i,
    input  logic             nxt_rdy_i,
    output logic [PW-1:0]    ptr_o,
    output logic [PW-1:0]    nxt_ptr_o,
    output logic             adv_o,
    output logic [EVT_W-1:0] set_o
);
    localparam logic [PW-1:0] LAST = PW'(NUM_DESC - 1);

    typedef struct packed {
        logic [PW-1:0] ptr;
    } st_t;

    st_t st_d, st_q;

    assign adv_o     = done_i && cur_rdy_i;
    assign nxt_ptr_o = (cur_wrap_i || st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;

    always_comb begin
        st_d = st_q;
        if (adv_o) begin
            st_d.ptr = nxt_ptr_o;
        end
    end

    always_comb begin
        set_o           = '0;
        set_o[EVT_DONE] = adv_o && cur_ien_i;
        set_o[EVT_BUSY] = IS_RX && adv_o && !nxt_rdy_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o = st_q.ptr;

    // R7
    wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_o && cur_wrap_i) |=> st_q.ptr == '0);

    // R9
    ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !adv_o |=> $stable(st_q.ptr));
endmodule

// File: rtl/rb_evt_unit.sv
module rb_evt_unit import rb_pkg::*; (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [EVT_W-1:0] set_i,
    input  logic [EVT_W-1:0] clr_i,
    input  logic             mask_we_i,
    input  logic [EVT_W-1:0] mask_i,
    output logic [EVT_W-1:0] evt_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [EVT_W-1:0] evt;
        logic [EVT_W-1:0] mask;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.evt = (st_q.evt & ~clr_i) | set_i;
        if (mask_we_i) begin
            st_d.mask = mask_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o = st_q.evt;
    assign irq_o = |(st_q.evt & st_q.mask);

    for (genvar b = 0; b < EVT_W; b++) begin : g_evt_chk
        // R11
        keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (st_q.evt[b] && !clr_i[b]) |=> st_q.evt[b]);
        // R11
        clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i[b] && !set_i[b]) |=> !st_q.evt[b]);
        // R6
        set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_i[b] |=> st_q.evt[b]);
    end
endmodule

// File: rtl/rb_ring_seq.sv
module rb_ring_seq import rb_pkg::*; #(
    parameter int NUM_DESC = 8,
    parameter int LEN_W    = 16,
    parameter int IDX_W    = 8,
    parameter bit IS_RX    = 1'b1,
    localparam int PW      = $clog2(NUM_DESC),
    localparam int DW      = 3 + LEN_W + IDX_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             host_we_i,
    input  logic [PW-1:0]    host_waddr_i,
    input  logic [DW-1:0]    host_wdata_i,
    input  logic [PW-1:0]    host_raddr_i,
    output logic [DW-1:0]    host_rdata_o,
    input  logic [EVT_W-1:0] evt_clr_i,
    input  logic             mask_we_i,
    input  logic [EVT_W-1:0] mask_wdata_i,
    input  logic             dp_done_i,
    input  logic [LEN_W-1:0] dp_len_i,
    output logic             cur_ready_o,
    output logic [PW-1:0]    cur_ptr_o,
    output logic [LEN_W-1:0] cur_len_o,
    output logic [IDX_W-1:0] cur_buf_o,
    output logic [EVT_W-1:0] evt_o,
    output logic             irq_o
);
    localparam int RDY_B  = DW - 1;
    localparam int IEN_B  = DW - 2;
    localparam int WRAP_B = DW - 3;

    logic [DW-1:0]    cur_w;
    logic [PW-1:0]    ptr_w;
    logic [PW-1:0]    nxt_ptr_w;
    logic             nxt_rdy_w;
    logic             adv_w;
    logic [EVT_W-1:0] set_w;

    rb_desc_store #(
        .NUM_DESC(NUM_DESC), .LEN_W(LEN_W), .IDX_W(IDX_W), .IS_RX(IS_RX)
    ) u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (host_we_i),
        .wr_addr_i (host_waddr_i),
        .wr_data_i (host_wdata_i),
        .rd_addr_i (host_raddr_i),
        .rd_data_o (host_rdata_o),
        .ptr_i     (ptr_w),
        .cmp_en_i  (adv_w),
        .cmp_len_i (dp_len_i),
        .nxt_ptr_i (nxt_ptr_w),
        .cur_o     (cur_w),
        .nxt_rdy_o (nxt_rdy_w)
    );

    rb_ptr_ctrl #(
        .NUM_DESC(NUM_DESC), .IS_RX(IS_RX)
    ) u_ptr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .done_i     (dp_done_i),
        .cur_rdy_i  (cur_w[RDY_B]),
        .cur_wrap_i (cur_w[WRAP_B]),
        .cur_ien_i  (cur_w[IEN_B]),
        .nxt_rdy_i  (nxt_rdy_w),
        .ptr_o      (ptr_w),
        .nxt_ptr_o  (nxt_ptr_w),
        .adv_o      (adv_w),
        .set_o      (set_w)
    );

    rb_evt_unit u_evt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_i     (set_w),
        .clr_i     (evt_clr_i),
        .mask_we_i (mask_we_i),
        .mask_i    (mask_wdata_i),
        .evt_o     (evt_o),
        .irq_o     (irq_o)
    );

    assign cur_ready_o = cur_w[RDY_B];
    assign cur_ptr_o   = ptr_w;
    assign cur_len_o   = cur_w[IDX_W +: LEN_W];
    assign cur_buf_o   = cur_w[IDX_W-1:0];

    // R9
    stall_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dp_done_i && !cur_ready_o && !host_we_i && evt_clr_i == '0)
        |=> $stable(evt_o) && $stable(cur_ptr_o));
endmodule

// File: tb/sim_rb_ring_seq.sv
module sim_rb_ring_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  waddr = '0;
    logic [26:0] wdata = '0;
    logic [2:0]  raddr = '0;
    logic [1:0]  clr = '0;
    logic        mwe = 1'b0;
    logic [1:0]  mdata = '0;
    logic        done = 1'b0;
    logic [15:0] dlen = '0;

    logic [26:0] rdata [2];
    logic        c_rdy [2];
    logic [2:0]  c_ptr [2];
    logic [15:0] c_len [2];
    logic [7:0]  c_buf [2];
    logic [1:0]  evt   [2];
    logic        irq   [2];

    logic [26:0] m_desc [2][8];
    logic [2:0]  m_ptr  [2];
    logic [1:0]  m_evt  [2];
    logic [1:0]  m_mask;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [31:0] rs = 32'h1234_5679;

    always #10 clk = ~clk;

    rb_ring_seq #(.IS_RX(1'b1)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .host_we_i(we), .host_waddr_i(waddr),
        .host_wdata_i(wdata), .host_raddr_i(raddr), .host_rdata_o(rdata[0]),
        .evt_clr_i(clr), .mask_we_i(mwe), .mask_wdata_i(mdata),
        .dp_done_i(done), .dp_len_i(dlen), .cur_ready_o(c_rdy[0]),
        .cur_ptr_o(c_ptr[0]), .cur_len_o(c_len[0]), .cur_buf_o(c_buf[0]),
        .evt_o(evt[0]), .irq_o(irq[0]));

    rb_ring_seq #(.IS_RX(1'b0)) u1 (
        .clk_i(clk), .rst_ni(rst_n), .host_we_i(we), .host_waddr_i(waddr),
        .host_wdata_i(wdata), .host_raddr_i(raddr), .host_rdata_o(rdata[1]),
        .evt_clr_i(clr), .mask_we_i(mwe), .mask_wdata_i(mdata),
        .dp_done_i(done), .dp_len_i(dlen), .cur_ready_o(c_rdy[1]),
        .cur_ptr_o(c_ptr[1]), .cur_len_o(c_len[1]), .cur_buf_o(c_buf[1]),
        .evt_o(evt[1]), .irq_o(irq[1]));

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [26:0] mk(input logic r, input logic i, input logic w,
                                       input logic [15:0] l, input logic [7:0] b);
        return {r, i, w, l, b};
    endfunction

    task automatic check_all();
        for (int k = 0; k < 2; k++) begin
            string nm = (k == 0) ? "rx" : "tx";
            logic [26:0] cd = m_desc[k][m_ptr[k]];
            chk("R7", {nm, " cur_ptr"}, 32'(c_ptr[k]), 32'(m_ptr[k]));
            chk("R3", {nm, " cur_ready"}, 32'(c_rdy[k]), 32'(cd[26]));
            chk("R3", {nm, " cur_len"}, 32'(c_len[k]), 32'(cd[23:8]));
            chk("R3", {nm, " cur_buf"}, 32'(c_buf[k]), 32'(cd[7:0]));
            chk("R6 R11", {nm, " done event"}, 32'(evt[k][0]), 32'(m_evt[k][0]));
            chk("R8 R11", {nm, " busy event"}, 32'(evt[k][1]), 32'(m_evt[k][1]));
            chk("R12", {nm, " irq"}, 32'(irq[k]), 32'(|(m_evt[k] & m_mask)));
        end
        for (int a = 0; a < 8; a++) begin
            raddr = 3'(a);
            #1;
            for (int k = 0; k < 2; k++) begin
                chk("R4", "desc ready", 32'(rdata[k][26]), 32'(m_desc[k][a][26]));
                chk("R5", "desc length", 32'(rdata[k][23:8]), 32'(m_desc[k][a][23:8]));
                chk("R2", "desc ien/wrap/buf", {rdata[k][25:24], rdata[k][7:0]},
                    {m_desc[k][a][25:24], m_desc[k][a][7:0]});
            end
        end
    endtask

    task automatic step(input logic s_we, input logic [2:0] s_wa, input logic [26:0] s_wd,
                        input logic s_dn, input logic [15:0] s_dl, input logic [1:0] s_cl,
                        input logic s_mwe, input logic [1:0] s_md);
        we = s_we; waddr = s_wa; wdata = s_wd; done = s_dn; dlen = s_dl;
        clr = s_cl; mwe = s_mwe; mdata = s_md;
        for (int k = 0; k < 2; k++) begin
            logic [26:0] old;
            logic [2:0]  p;
            logic [2:0]  np;
            logic [1:0]  st;
            p   = m_ptr[k];
            old = m_desc[k][p];
            st  = 2'b00;
            if (s_we) m_desc[k][s_wa] = s_wd;
            if (s_dn && old[26]) begin
                m_desc[k][p][26] = 1'b0;
                if (k == 0) m_desc[k][p][23:8] = s_dl;
                st[0] = old[25];
                np = (old[24] || p == 3'd7) ? 3'd0 : p + 3'd1;
                if (k == 0 && !m_desc[k][np][26]) st[1] = 1'b1;
                m_ptr[k] = np;
            end
            m_evt[k] = (m_evt[k] & ~s_cl) | st;
        end
        if (s_mwe) m_mask = s_md;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0; done = 1'b0; clr = '0; mwe = 1'b0;
        check_all();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            for (int a = 0; a < 8; a++) m_desc[k][a] = '0;
            m_ptr[k] = '0;
            m_evt[k] = '0;
        end
        m_mask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of both variants
        chk("R1", "rx evt after reset", 32'(evt[0]), 0);
        chk("R1", "tx irq after reset", 32'(irq[1]), 0);
        check_all();

        step(0, 0, 0, 0, 0, 0, 1, 2'b11);
        // Short ring: three entries, wrap on entry 2, interrupt only on entry 1
        step(1, 3'd0, mk(1, 0, 0, 16'd40, 8'd10), 0, 0, 0, 0, 0);
        step(1, 3'd1, mk(1, 1, 0, 16'd41, 8'd11), 0, 0, 0, 0, 0);
        step(1, 3'd2, mk(1, 0, 1, 16'd42, 8'd12), 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 16'd5, 0, 0, 0);
        chk("R6", "no done event for ien=0", 32'(evt[0][0]), 0);
        step(0, 0, 0, 1, 16'd6, 0, 0, 0);
        chk("R6", "done event for ien=1", 32'(evt[0][0]), 1);
        step(0, 0, 0, 1, 16'd7, 0, 0, 0);
        chk("R7", "wrap back to 0", 32'(c_ptr[0]), 0);
        chk("R8", "rx busy when ring dry", 32'(evt[0][1]), 1);
        chk("R8", "tx never busy", 32'(evt[1][1]), 0);
        // R9: completion while stalled is ignored
        step(0, 0, 0, 1, 16'd99, 0, 0, 0);
        chk("R9", "ptr held while stalled", 32'(c_ptr[0]), 0);
        step(0, 0, 0, 0, 0, 2'b11, 0, 0);
        chk("R11", "events cleared", 32'(evt[0]), 0);
        // R10: re-arm the waiting entry and resume
        step(1, 3'd0, mk(1, 1, 0, 16'd50, 8'd20), 0, 0, 0, 0, 0);
        chk("R10", "cur_ready after re-arm", 32'(c_rdy[0]), 1);
        step(0, 0, 0, 1, 16'd8, 0, 0, 0);
        chk("R10", "resumed to entry 1", 32'(c_ptr[0]), 1);
        // R11: set and clear of the done event in one cycle, set wins
        step(0, 0, 0, 0, 0, 2'b11, 0, 0);
        step(1, 3'd1, mk(1, 1, 0, 16'd60, 8'd21), 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 16'd9, 2'b01, 0, 0);
        chk("R11", "set wins over clear", 32'(evt[0][0]), 1);

        // Pseudo-random mix over both variants
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            rs = rs ^ (rs << 13);
            rs = rs ^ (rs >> 17);
            rs = rs ^ (rs << 5);
            r = rs;
            step(r[0] & (r[1] | r[2]), r[5:3],
                 mk(r[6] | r[7], r[8], r[9] & r[10], {4'h0, r[22:11]}, r[30:23]),
                 r[11] | r[12], {r[31:24], r[7:0]},
                 (r[13] & r[14]) ? r[16:15] : 2'b00,
                 r[17] & r[18] & r[19], r[21:20]);
        end
        summary();
    end
endmodule